// File: doc/BRIEF.md
# Core Register File with Operand Shadow Bank

This block is the integer register file of a single-issue core, extended with a small bank of three shadow registers. The core file has two combinational read ports and one write port. A write from the writeback stage always targets the addressed core register. A 2-bit copy field that comes with the write can also place the same result into one of the shadow registers.

Only the custom-instruction unit sees the shadow registers. It has two extra operand ports, one for the third operand and one for the fourth. Each port names a shadow register through a 2-bit select. An extended instruction can therefore get three or four operands in the cycle it issues, while the core file keeps its two read ports. A one-cycle move port copies a core register into a shadow register for values that no earlier writeback copied.

Every read path has a bypass from the write that happens in the same cycle, so a reader sees the value that is being written. The reset is synchronous and clears the core file and the shadow bank.

Top module: `shadow_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every core register and every shadow register is set to zero.
- R2: Core register 0 always reads as zero on both read ports. A write to address 0 leaves it at zero.
- R3: With `wr_en` high and a nonzero `wr_addr`, `wr_data` is stored in that core register at the rising edge. From then on, both read ports return it when they address that register.
- R4: With `wr_en` high, copy code `wr_cp` 0, 1 or 2 also stores `wr_data` into shadow register 0, 1 or 2, whatever the value of `wr_addr`. Code 3 leaves all shadow registers unchanged.
- R5: With `wr_en` low, neither the core file nor the shadow bank changes, whatever the values of `wr_addr`, `wr_data` and `wr_cp`.
- R6: When a read port addresses a nonzero register that is being written in the same cycle, the port returns `wr_data`.
- R7: When an extended operand port selects a shadow register that the current writeback copies into, the port returns `wr_data` in the same cycle. When only an active move targets that shadow register, the port returns the move value.
- R8: With `mv_en` high and `mv_dst` equal to 0, 1 or 2, the core value at `mv_src` is copied into that shadow register at the next edge. The source read follows R2 and R6. `mv_dst` equal to 3 has no effect. When the writeback copy and the move target the same shadow register, the writeback copy wins.
- R9: An operand port whose enable is high and whose select is 3 drives zero and raises `ext_err`. An operand port whose enable is low drives zero and never raises `ext_err`.
- R10: Shadow register contents never appear on the core read ports. Moves and shadow copies leave the core read results unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Writeback enable |
| wr_addr | input | 5 | Core register written |
| wr_data | input | 32 | Writeback result |
| wr_cp | input | 2 | Shadow copy code: 0..2 picks the shadow register, 3 means no copy |
| mv_en | input | 1 | Move enable |
| mv_src | input | 5 | Core register that is the move source |
| mv_dst | input | 2 | Shadow register that is the move target, 3 means none |
| rd_addr_a | input | 5 | Core read port A address |
| rd_addr_b | input | 5 | Core read port B address |
| rd_data_a | output | 32 | Core read port A data |
| rd_data_b | output | 32 | Core read port B data |
| ext_use_c | input | 1 | Third operand enable |
| ext_sel_c | input | 2 | Shadow select for the third operand |
| ext_use_d | input | 1 | Fourth operand enable |
| ext_sel_d | input | 2 | Shadow select for the fourth operand |
| ext_data_c | output | 32 | Third operand data |
| ext_data_d | output | 32 | Fourth operand data |
| ext_err | output | 1 | Illegal shadow select on an enabled operand |

## Verification
The following rules are checked on every cycle:
- register 0 reads as zero;
- the same-cycle bypass on the core ports;
- a write shows up on the next cycle;
- a shadow copy shows up on the following cycle;
- the error flag and zero output for a select of 3;
- a move from register 0 yields zero.

Other behaviour can only be shown by the bench scenarios:
- the reset clearing state that was written earlier;
- a disabled writeback leaving every register untouched;
- copy code 3 preserving the shadow bank;
- the priority between writeback copy and move;
- core reads staying unaffected by shadow traffic.

Each scenario is compared against a reference model of both banks.

// File: rtl/shadow_regfile.sv
module shadow_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    wr_cp,
  input  logic          mv_en,
  input  logic [AW-1:0] mv_src,
  input  logic [1:0]    mv_dst,
  input  logic [AW-1:0] rd_addr_a,
  input  logic [AW-1:0] rd_addr_b,
  output logic [DW-1:0] rd_data_a,
  output logic [DW-1:0] rd_data_b,
  input  logic          ext_use_c,
  input  logic [1:0]    ext_sel_c,
  input  logic          ext_use_d,
  input  logic [1:0]    ext_sel_d,
  output logic [DW-1:0] ext_data_c,
  output logic [DW-1:0] ext_data_d,
  output logic          ext_err
);
  localparam int NSH = 3;

  logic [DW-1:0] core_q [NREG];
  logic [DW-1:0] sh_q   [NSH];
  logic [DW-1:0] mv_val;
  logic          core_we;

  assign core_we = wr_en && (wr_addr != '0);

  function automatic logic [DW-1:0] core_rd(input logic [AW-1:0] a);
    if (a == '0)                   return '0;
    else if (core_we && wr_addr == a) return wr_data;
    else                           return core_q[a];
  endfunction

  function automatic logic [DW-1:0] sh_rd(input logic [1:0] s);
    logic [DW-1:0] v;
    case (s)
      2'd0:    v = sh_q[0];
      2'd1:    v = sh_q[1];
      2'd2:    v = sh_q[2];
      default: v = '0;
    endcase
    if (s == 2'd3)                  return '0;
    else if (wr_en && wr_cp == s)   return wr_data;
    else if (mv_en && mv_dst == s)  return mv_val;
    else                            return v;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) core_q[i] <= '0;
    end else if (core_we) begin
      core_q[wr_addr] <= wr_data;
    end
  end

  assign mv_val = core_rd(mv_src);

  for (genvar g = 0; g < NSH; g++) begin : g_sh
    always_ff @(posedge clk) begin
      if (rst)
        sh_q[g] <= '0;
      else if (wr_en && wr_cp == 2'(g))
        sh_q[g] <= wr_data;
      else if (mv_en && mv_dst == 2'(g))
        sh_q[g] <= mv_val;
    end
  end

  assign rd_data_a  = core_rd(rd_addr_a);
  assign rd_data_b  = core_rd(rd_addr_b);
  assign ext_data_c = ext_use_c ? sh_rd(ext_sel_c) : '0;
  assign ext_data_d = ext_use_d ? sh_rd(ext_sel_d) : '0;
  assign ext_err    = (ext_use_c && ext_sel_c == 2'd3) ||
                      (ext_use_d && ext_sel_d == 2'd3);
endmodule

module shadow_regfile_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [1:0]    wr_cp,
  input logic          mv_en,
  input logic [AW-1:0] mv_src,
  input logic [1:0]    mv_dst,
  input logic [AW-1:0] rd_addr_a,
  input logic [AW-1:0] rd_addr_b,
  input logic [DW-1:0] rd_data_a,
  input logic [DW-1:0] rd_data_b,
  input logic          ext_use_c,
  input logic [1:0]    ext_sel_c,
  input logic          ext_use_d,
  input logic [1:0]    ext_sel_d,
  input logic [DW-1:0] ext_data_c,
  input logic [DW-1:0] ext_data_d,
  input logic          ext_err
);
  assert_zero_reg_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == '0) |-> (rd_data_a == '0));

  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0 && rd_addr_b == wr_addr) |-> (rd_data_b == wr_data));

  assert_write_seen_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != '0) |=>
      (!(rd_addr_a == $past(wr_addr) && !(wr_en && wr_addr == rd_addr_a))
       || rd_data_a == $past(wr_data)));

  assert_copy_seen_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_cp != 2'd3) |=>
      (!(ext_use_c && ext_sel_c == $past(wr_cp) && !(wr_en && wr_cp == ext_sel_c)
         && !(mv_en && mv_dst == ext_sel_c))
       || ext_data_c == $past(wr_data)));

  assert_bad_sel_R9: assert property (@(posedge clk) disable iff (rst)
    (ext_use_d && ext_sel_d == 2'd3) |-> (ext_err && ext_data_d == '0));

  assert_no_err_R9: assert property (@(posedge clk) disable iff (rst)
    (!(ext_use_c && ext_sel_c == 2'd3) && !(ext_use_d && ext_sel_d == 2'd3)) |-> !ext_err);

  assert_move_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (mv_en && mv_src == '0 && mv_dst != 2'd3 && !(wr_en && wr_cp == mv_dst)) |=>
      (!(ext_use_c && ext_sel_c == $past(mv_dst) && !(wr_en && wr_cp == ext_sel_c)
         && !(mv_en && mv_dst == ext_sel_c))
       || ext_data_c == '0));
endmodule

bind shadow_regfile shadow_regfile_chk #(.DW(DW), .AW(AW)) u_chk (.*);

// File: tb/tb_shadow_regfile.sv
module tb_shadow_regfile;
  logic        clk = 0;
  logic        rst;
  logic        wr_en, mv_en, ext_use_c, ext_use_d;
  logic [4:0]  wr_addr, mv_src, rd_addr_a, rd_addr_b;
  logic [31:0] wr_data;
  logic [1:0]  wr_cp, mv_dst, ext_sel_c, ext_sel_d;
  logic [31:0] rd_data_a, rd_data_b, ext_data_c, ext_data_d;
  logic        ext_err;

  int n_tests = 0, n_fail = 0;
  logic [31:0] m_core [32];
  logic [31:0] m_sh   [3];

  always #2 clk = ~clk;

  shadow_regfile dut (.*);

  function automatic logic [31:0] e_core(input logic [4:0] a);
    if (a == 0) return 0;
    if (wr_en && wr_addr == a) return wr_data;
    return m_core[a];
  endfunction

  function automatic logic [31:0] e_sh(input logic use_i, input logic [1:0] s);
    if (!use_i || s == 3) return 0;
    if (wr_en && wr_cp == s) return wr_data;
    if (mv_en && mv_dst == s) return e_core(mv_src);
    return m_sh[s];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_addr = 0; wr_data = 0; wr_cp = 3;
    mv_en = 0; mv_src = 0; mv_dst = 3;
    rd_addr_a = 0; rd_addr_b = 0;
    ext_use_c = 0; ext_sel_c = 0; ext_use_d = 0; ext_sel_d = 0;
  endtask

  // Checks all outputs during the current cycle, then advances the model at the edge
  task automatic step(input string tag);
    string ta, tb, tc, td;
    #0.5;
    ta = (tag != "") ? tag : (rd_addr_a == 0) ? "R2" : (wr_en && wr_addr == rd_addr_a) ? "R6" : "R3";
    tb = (tag != "") ? tag : (rd_addr_b == 0) ? "R2" : (wr_en && wr_addr == rd_addr_b) ? "R6" : "R3";
    tc = (tag != "") ? tag : ((wr_en && wr_cp == ext_sel_c) || (mv_en && mv_dst == ext_sel_c)) ? "R7" : "R4";
    td = (tag != "") ? tag : ((wr_en && wr_cp == ext_sel_d) || (mv_en && mv_dst == ext_sel_d)) ? "R7" : "R4";
    if (!rst) begin
      chk(ta, rd_data_a, e_core(rd_addr_a));
      chk(tb, rd_data_b, e_core(rd_addr_b));
      chk(tc, ext_data_c, e_sh(ext_use_c, ext_sel_c));
      chk(td, ext_data_d, e_sh(ext_use_d, ext_sel_d));
      chk((tag != "") ? tag : "R9", 32'(ext_err),
          32'((ext_use_c && ext_sel_c == 3) || (ext_use_d && ext_sel_d == 3)));
    end
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < 32; i++) m_core[i] = 0;
      for (int i = 0; i < 3; i++) m_sh[i] = 0;
    end else begin
      logic [31:0] mv = e_core(mv_src);
      for (int i = 0; i < 3; i++) begin
        if (wr_en && wr_cp == 2'(i)) m_sh[i] = wr_data;
        else if (mv_en && mv_dst == 2'(i)) m_sh[i] = mv;
      end
      if (wr_en && wr_addr != 0) m_core[wr_addr] = wr_data;
    end
    @(negedge clk);
    idle();
  endtask

  task automatic peek(input string tag, input logic [4:0] a, input logic [1:0] s);
    rd_addr_a = a; rd_addr_b = a; ext_use_c = 1; ext_sel_c = s;
    step(tag);
  endtask

  initial begin
    #800000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < 32; i++) m_core[i] = 'x;
    for (int i = 0; i < 3; i++) m_sh[i] = 'x;
    idle();
    rst = 1;
    @(negedge clk);
    // Dirty the state under reset, then check that everything is cleared
    wr_en = 1; wr_addr = 7; wr_data = 32'hdead; wr_cp = 1; step("R1");
    step("R1");
    rst = 0;
    for (int i = 0; i < 32; i++) begin
      rd_addr_a = 5'(i); rd_addr_b = 5'(31 - i);
      ext_use_c = 1; ext_sel_c = 2'(i % 3); ext_use_d = 1; ext_sel_d = 2'((i + 1) % 3);
      step("R1");
    end
    // R2: a write to register 0 is dropped
    wr_en = 1; wr_addr = 0; wr_data = 32'h1234_5678; rd_addr_a = 0; step("R2");
    peek("R2", 0, 0);
    // R3 and R4: write with copy into shadow 2, then read it back
    wr_en = 1; wr_addr = 9; wr_data = 32'hcafe_0009; wr_cp = 2; step("R4");
    peek("R3", 9, 2);
    // R4: copy code 3 leaves the shadows alone
    wr_en = 1; wr_addr = 10; wr_data = 32'h0000_aaaa; wr_cp = 3; step("R4");
    peek("R4", 10, 2);
    // R5: a disabled writeback changes nothing
    wr_en = 0; wr_addr = 9; wr_data = 32'hbad0_bad0; wr_cp = 2; step("R5");
    peek("R5", 9, 2);
    // R6 and R7: same-cycle bypass
    wr_en = 1; wr_addr = 12; wr_data = 32'h0bb0_0012; wr_cp = 0;
    rd_addr_a = 12; ext_use_c = 1; ext_sel_c = 0; step("R6");
    mv_en = 1; mv_src = 9; mv_dst = 1; ext_use_d = 1; ext_sel_d = 1; step("R7");
    // R8: the move is stored; a move to target 3 has no effect; writeback beats move
    peek("R8", 9, 1);
    mv_en = 1; mv_src = 12; mv_dst = 3; step("R8");
    peek("R8", 12, 1);
    wr_en = 1; wr_addr = 3; wr_data = 32'h7777_0003; wr_cp = 0;
    mv_en = 1; mv_src = 9; mv_dst = 0; step("R8");
    peek("R8", 3, 0);
    // R9: an illegal select is flagged only on an enabled port
    ext_use_c = 1; ext_sel_c = 3; step("R9");
    ext_use_c = 0; ext_sel_c = 3; ext_use_d = 1; ext_sel_d = 2; step("R9");
    ext_use_d = 1; ext_sel_d = 3; step("R9");
    // R10: a move into a shadow register leaves the core reads untouched
    mv_en = 1; mv_src = 10; mv_dst = 2; rd_addr_a = 10; rd_addr_b = 9; step("R10");
    rd_addr_a = 10; rd_addr_b = 9; step("R10");
    // Random mix, with an occasional reset
    for (int n = 0; n < 3000; n++) begin
      rst       = ($urandom % 200) == 0;
      wr_en     = ($urandom % 4) != 0;
      wr_addr   = 5'($urandom % 8);
      wr_data   = $urandom;
      wr_cp     = 2'($urandom);
      mv_en     = ($urandom % 3) == 0;
      mv_src    = 5'($urandom % 8);
      mv_dst    = 2'($urandom);
      rd_addr_a = 5'($urandom % 8);
      rd_addr_b = 5'($urandom % 8);
      ext_use_c = 1'($urandom);
      ext_sel_c = 2'($urandom);
      ext_use_d = 1'($urandom);
      ext_sel_d = 2'($urandom);
      step(rst ? "R1" : "");
      rst = 0;
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule